// File: doc/BRIEF.md
# SPI Register Slave with Fast Readback

This block is the serial front end of a small register-mapped converter. A host shifts 24-bit frames into it, most significant bit first, while an active-low select is held low. The top bit of each frame marks a read, the next seven bits address one of a small bank of 16-bit registers, and the low sixteen bits carry write data. A write lands in the bank when select rises after exactly 24 falling clock edges. A read is answered in the following frame: that frame's first eight output bits repeat the read command's upper byte, and the register contents are loaded into the output path at the eighth falling edge and fill the lower sixteen bits. When the previous frame was not a read, the output simply replays the previous frame, so several slaves can be chained.

The serial output is a data bit plus an output enable. The enable is active only while select is low. Bit 0 of the register at address 3 selects fast output timing. In that mode each output bit launches on a falling clock edge, half a clock earlier than the normal rising-edge launch. The serial clock may idle high or low. Each accepted write is handed to the system clock domain as a single-cycle strobe with its address and data, through a two-stage synchronizer.

Top module: `spi_reg_slave`

## Requirements
- R1: `spi_sdo_oe` is 1 only while `spi_cs_n` is 0; while `spi_cs_n` is 1 both `spi_sdo_oe` and `spi_sdo` are 0.
- R2: SDI is sampled on falling edges of `spi_sclk`, frame bit 23 first; bit 23 is the read flag (1 = read), bits 22..16 the address, bits 15..0 the write data.
- R3: A write frame to an address below NUM_REGS (8) updates that register when `spi_cs_n` rises; a write to a higher address changes nothing, and reading such an address returns 16'h0000.
- R4: A frame whose falling-edge count is not exactly 24 is discarded: no register write, no strobe, and the pending read or replay state of the previous accepted frame is kept.
- R5: With fast timing off, SDO changes only on rising edges of `spi_sclk`; after the first falling edge and before the next rising edge it still shows frame bit 23.
- R6: With fast timing on, SDO shows frame bit 23 from the moment `spi_cs_n` falls and moves to the next bit on each falling edge.
- R7: Both timing modes work with `spi_sclk` idling high or low when `spi_cs_n` falls; a rising edge before the first falling edge does not advance SDO.
- R8: In the frame after an accepted read, SDO carries the read command's bits 23..16 followed by the addressed register's 16-bit contents, loaded at the eighth falling edge.
- R9: In the frame after an accepted non-read frame, SDO carries that previous frame's 24 bits unchanged.
- R10: Fast timing is bit 0 of the register at address 3, resets to 0, and applies from the frame after the write that sets it.
- R11: Each accepted in-range write gives exactly one `wr_stb` pulse of one `sys_clk` cycle with the written address on `wr_addr` and data on `wr_data`; other frames give none.
- R12: After `sys_rst_n` every register is 0 and the first frame's SDO is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the write strobe side |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, 0 when not enabled |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad |
| wr_stb | output | 1 | One-cycle pulse per accepted write, in `sys_clk` domain |
| wr_addr | output | 7 | Address of the last accepted write |
| wr_data | output | 16 | Data of the last accepted write |

## Verification
A wrong edge count or a stale first-edge flag shows as a one-bit shift of the whole SDO word in the very next frame, or as a discarded frame that still writes. A wrong pending-read or replay state shows in the following frame's upper byte or lower half. A wrong mode bit shows within one half-clock of the first falling edge, since normal timing must still show bit 23 there while fast timing has already moved to bit 22. Strobe faults show within a few system cycles after select rises.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 16;
  localparam int HDR_W      = FRAME_BITS - DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX    = FRAME_BITS + 1;

  typedef logic [FRAME_BITS-1:0] frame_t;

  function automatic logic frame_is_read(input frame_t f);
    return f[FRAME_BITS-1];
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input frame_t f);
    return f[FRAME_BITS-2 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input frame_t f);
    return f[DATA_W-1:0];
  endfunction

  // Bit number idx of the outgoing word, counted from the MSB; 0 past the end.
  function automatic logic sdo_pick(input frame_t w, input int idx);
    frame_t t;
    t = w << idx;
    return t[FRAME_BITS-1];
  endfunction
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_reg_pkg::*;
(
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             sys_rst_n,
  input  logic             spi_sdi,
  output frame_t           frame_q,
  output logic [CNT_W-1:0] fall_cnt,
  output logic [CNT_W-1:0] fall_cnt_now,
  output logic [CNT_W-1:0] rise_cnt,
  output logic             frame_id
);
  logic frame_rst;
  logic first_q;

  assign frame_rst = spi_cs_n | ~sys_rst_n;

  // Held set while select is high; cleared by the first falling edge.
  always_ff @(negedge spi_sclk or posedge frame_rst) begin
    if (frame_rst) first_q <= 1'b1;
    else           first_q <= 1'b0;
  end

  assign fall_cnt_now = first_q ? '0 : fall_cnt;

  // The count survives select rising so the commit logic can read it.
  always_ff @(negedge spi_sclk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      fall_cnt <= '0;
      frame_id <= 1'b0;
      frame_q  <= '0;
    end else if (!spi_cs_n) begin
      fall_cnt <= (fall_cnt_now == CNT_W'(CNT_MAX)) ? CNT_W'(CNT_MAX)
                                                    : fall_cnt_now + CNT_W'(1);
      if (first_q) frame_id <= ~frame_id;
      frame_q <= {frame_q[FRAME_BITS-2:0], spi_sdi};
    end
  end

  // Rising edges that follow a falling edge of this frame.
  always_ff @(posedge spi_sclk or posedge frame_rst) begin
    if (frame_rst) rise_cnt <= '0;
    else           rise_cnt <= fall_cnt_now;
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int CFG_ADDR = 3,
  parameter int FAST_BIT = 0
) (
  input  logic              spi_cs_n,
  input  logic              sys_rst_n,
  input  frame_t            frame_q,
  input  logic [CNT_W-1:0]  fall_cnt,
  input  logic              frame_id,
  output logic              fast_mode,
  output logic [HDR_W-1:0]  hdr_byte,
  output logic [DATA_W-1:0] rb_word,
  output logic              wr_toggle,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              commit_ok
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] CFG_IDX = IDX_W'(CFG_ADDR);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  frame_t            last_q;
  logic              pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              seen_id_q;
  logic              cmd_rd, cmd_hit;
  logic [ADDR_W-1:0] cmd_addr;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return int'(a) < NUM_REGS;
  endfunction

  assign cmd_rd    = frame_is_read(frame_q);
  assign cmd_addr  = frame_addr(frame_q);
  assign cmd_hit   = in_range(cmd_addr);
  assign commit_ok = (fall_cnt == CNT_W'(FRAME_BITS)) && (frame_id != seen_id_q);

  always_ff @(posedge spi_cs_n or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      last_q    <= '0;
      pend_q    <= 1'b0;
      rd_addr_q <= '0;
      seen_id_q <= 1'b0;
      wr_toggle <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      seen_id_q <= frame_id;
      if (commit_ok) begin
        last_q    <= frame_q;
        pend_q    <= cmd_rd;
        rd_addr_q <= cmd_addr;
        if (!cmd_rd && cmd_hit) begin
          regs_q[cmd_addr[IDX_W-1:0]] <= frame_data(frame_q);
          wr_toggle <= ~wr_toggle;
          hold_addr <= cmd_addr;
          hold_data <= frame_data(frame_q);
        end
      end
    end
  end

  assign fast_mode = regs_q[CFG_IDX][FAST_BIT];
  assign hdr_byte  = last_q[FRAME_BITS-1 -: HDR_W];

  always_comb begin
    if (!pend_q)                  rb_word = frame_data(last_q);
    else if (in_range(rd_addr_q)) rb_word = regs_q[rd_addr_q[IDX_W-1:0]];
    else                          rb_word = '0;
  end
endmodule

// File: rtl/spi_sdo_tx.sv
module spi_sdo_tx
  import spi_reg_pkg::*;
(
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              sys_rst_n,
  input  logic              fast_mode,
  input  logic [CNT_W-1:0]  fall_cnt_now,
  input  logic [CNT_W-1:0]  rise_cnt,
  input  logic [HDR_W-1:0]  hdr_byte,
  input  logic [DATA_W-1:0] rb_word,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              load_evt
);
  logic [DATA_W-1:0] low_q;
  logic [CNT_W-1:0]  bit_idx;

  // Eighth falling edge of the frame.
  assign load_evt = (fall_cnt_now == CNT_W'(HDR_W - 1));

  always_ff @(negedge spi_sclk or negedge sys_rst_n) begin
    if (!sys_rst_n)    low_q <= '0;
    else if (load_evt) low_q <= rb_word;
  end

  assign bit_idx    = fast_mode ? fall_cnt_now : rise_cnt;
  assign spi_sdo_oe = ~spi_cs_n;
  assign spi_sdo    = ~spi_cs_n & sdo_pick({hdr_byte, low_q}, int'(bit_idx));
endmodule

// File: rtl/spi_wr_sync.sv
module spi_wr_sync
  import spi_reg_pkg::*;
(
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              wr_toggle,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0] tog_q;
  logic       tog_edge;

  assign tog_edge = tog_q[1] ^ tog_q[2];

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      tog_q   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      tog_q  <= {tog_q[1:0], wr_toggle};
      wr_stb <= tog_edge;
      if (tog_edge) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int CFG_ADDR = 3,
  parameter int FAST_BIT = 0
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  frame_t            frame_q;
  logic [CNT_W-1:0]  fall_cnt, fall_cnt_now, rise_cnt;
  logic              frame_id;
  logic              fast_mode;
  logic [HDR_W-1:0]  hdr_byte;
  logic [DATA_W-1:0] rb_word;
  logic              wr_toggle;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              commit_ok;
  logic              load_evt;

  spi_frame_rx u_rx (
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .sys_rst_n(sys_rst_n),
    .spi_sdi(spi_sdi), .frame_q(frame_q), .fall_cnt(fall_cnt),
    .fall_cnt_now(fall_cnt_now), .rise_cnt(rise_cnt), .frame_id(frame_id)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS), .CFG_ADDR(CFG_ADDR), .FAST_BIT(FAST_BIT)) u_bank (
    .spi_cs_n(spi_cs_n), .sys_rst_n(sys_rst_n), .frame_q(frame_q),
    .fall_cnt(fall_cnt), .frame_id(frame_id), .fast_mode(fast_mode),
    .hdr_byte(hdr_byte), .rb_word(rb_word), .wr_toggle(wr_toggle),
    .hold_addr(hold_addr), .hold_data(hold_data), .commit_ok(commit_ok)
  );

  spi_sdo_tx u_tx (
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .sys_rst_n(sys_rst_n),
    .fast_mode(fast_mode), .fall_cnt_now(fall_cnt_now), .rise_cnt(rise_cnt),
    .hdr_byte(hdr_byte), .rb_word(rb_word), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .load_evt(load_evt)
  );

  spi_wr_sync u_sync (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_toggle(wr_toggle),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic              sys_clk,
  input logic              sys_rst_n,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_sdo,
  input logic              spi_sdo_oe,
  input logic              fast_mode,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data
);
  logic frame_rst;
  logic sdo_pre_fall, sdo_pre_rise;
  logic fall_seen, rise_seen;

  assign frame_rst = spi_cs_n | ~sys_rst_n;

  always_ff @(negedge spi_sclk or posedge frame_rst) begin
    if (frame_rst) begin
      fall_seen    <= 1'b0;
      sdo_pre_fall <= 1'b0;
    end else begin
      fall_seen    <= 1'b1;
      sdo_pre_fall <= spi_sdo;
    end
  end

  always_ff @(posedge spi_sclk or posedge frame_rst) begin
    if (frame_rst) begin
      rise_seen    <= 1'b0;
      sdo_pre_rise <= 1'b0;
    end else begin
      rise_seen    <= 1'b1;
      sdo_pre_rise <= spi_sdo;
    end
  end

  // R1
  sdo_idle_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    spi_cs_n |-> (!spi_sdo_oe && !spi_sdo));

  // R5
  norm_fall_hold_chk: assert property (@(posedge spi_sclk) disable iff (frame_rst)
    (!fast_mode && fall_seen) |-> (spi_sdo == sdo_pre_fall));

  // R6
  fast_rise_hold_chk: assert property (@(negedge spi_sclk) disable iff (frame_rst)
    (fast_mode && rise_seen) |-> (spi_sdo == sdo_pre_rise));

  // R11
  stb_single_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wr_stb |=> !wr_stb);

  // R11
  stb_data_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wr_stb |=> $stable(wr_data));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
  .fast_mode(fast_mode), .wr_stb(wr_stb), .wr_data(wr_data)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam int H = 20;

  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        spi_sclk = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sdi = 1'b0;
  logic        spi_sdo, spi_sdo_oe, wr_stb;
  logic [6:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  logic [6:0]  st_addr = '0;
  logic [15:0] st_data = '0;

  logic [15:0] m_regs [8];
  logic [23:0] m_last;
  bit          m_pend;
  logic [6:0]  m_raddr;

  spi_reg_slave uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #5 sys_clk = ~sys_clk;

  always @(posedge sys_clk) begin
    if (wr_stb) begin
      stb_cnt++;
      st_addr = wr_addr;
      st_data = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word();
    logic [15:0] lo;
    if (!m_pend)           lo = m_last[15:0];
    else if (m_raddr < 8)  lo = m_regs[m_raddr[2:0]];
    else                   lo = 16'h0000;
    return {m_last[23:16], lo};
  endfunction

  // One frame of n falling edges; checks SDO word, launch edge, enable and strobe.
  task automatic xfer(input logic [23:0] tx, input int n, input bit idle_hi, input string tag);
    logic [23:0] expw, pre;
    logic        post_b [24];
    bit          fast;
    int          s0, bad_k;
    logic        e;
    expw = exp_word();
    fast = m_regs[3][0];
    s0   = stb_cnt;
    pre  = '0;
    for (int i = 0; i < 24; i++) post_b[i] = 1'b0;
    spi_sclk = idle_hi;
    #H;
    spi_cs_n = 1'b0;
    #2;
    chk(spi_sdo_oe === 1'b1, "R1 enable in frame", 32'(spi_sdo_oe), 1);
    #(H-2);
    if (!idle_hi) begin spi_sclk = 1'b1; #H; end
    for (int k = 0; k < n; k++) begin
      spi_sdi = (k < 24) ? tx[23-k] : 1'b0;
      #(H/2);
      if (k < 24) pre[23-k] = spi_sdo;
      #(H/2);
      spi_sclk = 1'b0;
      #2;
      if (k + 1 < 24) post_b[k+1] = spi_sdo;
      #(H-2);
      if (k < n-1 || idle_hi) begin spi_sclk = 1'b1; #H; end
    end
    spi_cs_n = 1'b1;
    #2;
    chk(spi_sdo_oe === 1'b0 && spi_sdo === 1'b0, "R1 idle output", {spi_sdo_oe, spi_sdo}, 0);
    #150;
    if (n == 24) begin
      chk(pre === expw, tag, 32'(pre), 32'(expw));
      bad_k = 0;
      for (int kk = 1; kk < 24; kk++) begin
        e = fast ? expw[23-kk] : expw[24-kk];
        if (post_b[kk] !== e && bad_k == 0) bad_k = kk;
      end
      chk(bad_k == 0, fast ? "R6 launch on fall" : "R5 launch on rise", bad_k, 0);
      m_last  = tx;
      m_pend  = tx[23];
      m_raddr = tx[22:16];
      if (!tx[23] && tx[22:16] < 8) begin
        m_regs[tx[18:16]] = tx[15:0];
        chk(stb_cnt == s0 + 1, "R11 one strobe", stb_cnt - s0, 1);
        chk(st_addr == tx[22:16] && st_data == tx[15:0], "R11 strobe payload",
            {9'd0, st_addr, st_data}, {9'd0, tx[22:0]});
      end else begin
        chk(stb_cnt == s0, "R11 no strobe", stb_cnt - s0, 0);
      end
    end else begin
      chk(stb_cnt == s0, "R4 discarded frame strobe", stb_cnt - s0, 0);
    end
  endtask

  task automatic t_reset();
    chk(spi_sdo_oe === 1'b0 && spi_sdo === 1'b0, "R12 reset output", {spi_sdo_oe, spi_sdo}, 0);
    chk(stb_cnt == 0 && wr_stb === 1'b0, "R12 reset strobe", stb_cnt, 0);
  endtask

  task automatic t_writes();
    xfer({1'b0, 7'h01, 16'hA5C3}, 24, 1'b1, "R12 first frame zero");
    xfer({1'b0, 7'h02, 16'h3C96}, 24, 1'b0, "R9 replay after write");
  endtask

  task automatic t_readback();
    xfer({1'b1, 7'h01, 16'h0000}, 24, 1'b1, "R9 replay before read");
    xfer({1'b1, 7'h02, 16'hFFFF}, 24, 1'b0, "R8 read reg1");
    xfer({1'b0, 7'h45, 16'h1234}, 24, 1'b1, "R8 read reg2 R2");
  endtask

  task automatic t_discard();
    xfer({1'b1, 7'h02, 16'h0000}, 24, 1'b1, "R3 replay of ignored write");
    xfer({1'b0, 7'h01, 16'hDEAD}, 20, 1'b1, "R4 short");
    xfer({1'b0, 7'h01, 16'hBEEF}, 26, 1'b0, "R4 long");
    xfer({1'b1, 7'h01, 16'h0000}, 24, 1'b1, "R4 pending read kept");
    xfer({1'b1, 7'h45, 16'h0000}, 24, 1'b0, "R4 reg1 unchanged");
    xfer({1'b0, 7'h00, 16'h0F0F}, 24, 1'b1, "R3 out of range reads zero");
  endtask

  task automatic t_fast();
    xfer({1'b0, 7'h03, 16'h0001}, 24, 1'b1, "R10 enable write");
    xfer({1'b1, 7'h03, 16'h0000}, 24, 1'b1, "R10 fast from next frame");
    xfer({1'b1, 7'h01, 16'h0000}, 24, 1'b0, "R7 fast idle low");
    xfer({1'b0, 7'h03, 16'h0000}, 24, 1'b1, "R7 fast idle high");
    xfer({1'b1, 7'h00, 16'h0000}, 24, 1'b0, "R7 normal idle low");
    xfer({1'b0, 7'h05, 16'h5A5A}, 24, 1'b1, "R8 read reg0");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_regs[i] = 16'h0000;
    m_last  = '0;
    m_pend  = 1'b0;
    m_raddr = '0;
    #47;
    t_reset();
    sys_rst_n = 1'b1;
    #40;
    t_writes();
    t_readback();
    t_discard();
    t_fast();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule